// File: doc/BRIEF.md
# Eight-Line Receive Scanner with Shared Character Queue

This block collects received characters from eight serial line receivers and funnels them into one queue that a host drains. A rotating scanner visits the lines one after another. Each visit is a step of four clock cycles: pick the line, test whether it holds a finished character, store the character, then tell the line it may drop its ready flag. Every stored word carries the number of the line it came from and that line's error flags. A single queue therefore serves all eight lines, and the host can empty several characters for each interrupt.

The host sees the oldest stored word at all times and removes it with a one-cycle read strobe. When the queue is empty, the word it sees has its valid bit clear. An interrupt request is raised while words are waiting and receive interrupts are enabled. If the queue is full when a line is tested, the scanner does not take the character and leaves the line's ready flag alone. The line's own overrun logic then accounts for any later loss, and the scanner takes the held character on a later visit once space has opened.

Top module: `rxs_scanner`

## Requirements
- R1: While reset is low, and in the first cycle after it, the queue is empty, `rd_data` is all zeros, `rx_avail` and `irq` are low, and `ln_clr` is zero. The scan begins at line 0.
- R2: The scan visits lines 0,1,...,7,0,... for four clock cycles each. A line's `ln_rdy`, data and error inputs are sampled at the first rising edge of its step.
- R3: A word taken from a ready line is written into the queue at the third rising edge of the step. Its layout within `rd_data[13:0]` is line number in [13:11], overrun in [10], framing error in [9], parity error in [8] and character in [7:0].
- R4: For a line whose character was stored, exactly one bit of `ln_clr` (bit = line number) is high, for one cycle, in the fourth cycle of the step. No bit is high otherwise.
- R5: If the queue holds 64 words when the ready line is tested, nothing is stored and no `ln_clr` bit rises. The line stays ready, and its character is taken on a later visit when space exists.
- R6: Words leave in arrival order. `rd_data` shows the oldest word, and a high `rd_en` at a rising edge removes it.
- R7: With the queue empty, `rd_data` is all zeros (valid bit [14] clear) and `rd_en` changes nothing. Bit [14] is set whenever a word is shown.
- R8: `rx_avail` is high exactly while the queue is non-empty. `irq` is high exactly while `rx_avail` and `rx_ie` are both high.
- R9: A store and a removal at the same edge both take effect, leaving the word count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ln_rdy | input | 8 | Per-line character-ready flags |
| ln_data | input | 64 | Per-line characters, line i at [8i+7:8i] |
| ln_ovr | input | 8 | Per-line overrun flags |
| ln_frm | input | 8 | Per-line framing-error flags |
| ln_par | input | 8 | Per-line parity-error flags |
| ln_clr | output | 8 | One-cycle ready-clear pulse per line |
| rd_en | input | 1 | Remove the shown word at the clock edge |
| rx_ie | input | 1 | Receive interrupt enable |
| rd_data | output | 15 | Oldest word: valid, line, flags, character |
| rx_avail | output | 1 | Queue non-empty |
| irq | output | 1 | Receive interrupt request |

## Verification
The scanner's store in the third cycle of a step can land on the same edge as a host removal. The bench provokes this by holding `rd_en` high across long stretches while all eight lines keep refilling, so that stores and removals coincide with one and with many words queued. A behavioural queue model applies the removal and the store at the same edge and is compared with `rd_data`, `rx_avail`, `irq` and `ln_clr` on every cycle. A wrong count or order shows up as a mismatched word or a wrong valid bit. A second collision, a full queue meeting a ready line, is produced by refilling beyond 64 words. It is judged by the missing clear pulse and by the line still being ready.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
    parameter int unsigned NUM_LINES  = 8;
    parameter int unsigned CHAR_W     = 8;
    parameter int unsigned FIFO_DEPTH = 64;
    localparam int unsigned LINE_W    = $clog2(NUM_LINES);

    typedef enum logic [1:0] {
        PH_SELECT = 2'd0,
        PH_TEST   = 2'd1,
        PH_WRITE  = 2'd2,
        PH_CLEAR  = 2'd3
    } scan_phase_e;

    typedef struct packed {
        logic ovr;
        logic frm;
        logic par;
    } rx_err_t;

    typedef struct packed {
        logic [LINE_W-1:0] line;
        rx_err_t           err;
        logic [CHAR_W-1:0] data;
    } rx_entry_t;

    localparam int unsigned ENTRY_W = $bits(rx_entry_t);
endpackage

// File: rtl/rxs_seq.sv
module rxs_seq
    import rxs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    output scan_phase_e       phase_o,
    output logic [LINE_W-1:0] line_o
);
    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(NUM_LINES - 1);

    typedef struct packed {
        scan_phase_e       phase;
        logic [LINE_W-1:0] line;
    } seq_state_t;

    seq_state_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.phase = scan_phase_e'(s_q.phase + 2'd1);
        if (s_q.phase == PH_CLEAR) begin
            s_d.line = (s_q.line == LAST_LINE) ? '0 : s_q.line + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_SELECT, line: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign phase_o = s_q.phase;
    assign line_o  = s_q.line;

    AST_LINE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_CLEAR) |=> (line_o == (($past(line_o) == LAST_LINE) ? '0 : $past(line_o) + 1'b1))); // R2
    AST_STEP_START: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_CLEAR) |=> (phase_o == PH_SELECT)); // R2
endmodule

// File: rtl/rxs_fifo.sv
module rxs_fifo
    import rxs_pkg::*;
#(
    parameter int unsigned DEPTH = FIFO_DEPTH
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push_i,
    input  rx_entry_t push_entry_i,
    input  logic      pop_i,
    output rx_entry_t head_o,
    output logic      empty_o,
    output logic      full_o
);
    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [CNT_W-1:0] count;
    } fifo_state_t;

    fifo_state_t f_d, f_q;
    rx_entry_t   mem [DEPTH];
    logic        do_push, do_pop;

    assign empty_o = (f_q.count == '0);
    assign full_o  = (f_q.count == FULL_CNT);
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;

    always_comb begin
        f_d = f_q;
        if (do_push) f_d.wptr = (f_q.wptr == LAST_PTR) ? '0 : f_q.wptr + 1'b1;
        if (do_pop)  f_d.rptr = (f_q.rptr == LAST_PTR) ? '0 : f_q.rptr + 1'b1;
        case ({do_push, do_pop})
            2'b10:   f_d.count = f_q.count + 1'b1;
            2'b01:   f_d.count = f_q.count - 1'b1;
            default: f_d.count = f_q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[f_q.wptr] <= push_entry_i;
    end

    assign head_o = mem[f_q.rptr];

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (f_q.count < FULL_CNT)); // R5
    AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && (f_q.count == '0) && !push_i) |=> (f_q.count == '0)); // R7
    AST_PUSH_POP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && (f_q.count != '0)) |=> $stable(f_q.count)); // R9
endmodule

// File: rtl/rxs_scanner.sv
module rxs_scanner
    import rxs_pkg::*;
#(
    parameter int unsigned RX_DEPTH = FIFO_DEPTH
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_LINES-1:0]          ln_rdy,
    input  logic [NUM_LINES*CHAR_W-1:0]   ln_data,
    input  logic [NUM_LINES-1:0]          ln_ovr,
    input  logic [NUM_LINES-1:0]          ln_frm,
    input  logic [NUM_LINES-1:0]          ln_par,
    output logic [NUM_LINES-1:0]          ln_clr,
    input  logic                          rd_en,
    input  logic                          rx_ie,
    output logic [ENTRY_W:0]              rd_data,
    output logic                          rx_avail,
    output logic                          irq
);
    typedef struct packed {
        logic      snap_rdy;
        rx_entry_t snap;
        logic      hit;
    } scan_state_t;

    scan_state_t       s_d, s_q;
    scan_phase_e       phase;
    logic [LINE_W-1:0] line;
    rx_entry_t         line_word [NUM_LINES];
    rx_entry_t         head;
    logic              q_empty, q_full, q_push;

    rxs_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_o (phase),
        .line_o  (line)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        assign line_word[g] = '{line: LINE_W'(g),
                                err:  '{ovr: ln_ovr[g], frm: ln_frm[g], par: ln_par[g]},
                                data: ln_data[g*CHAR_W +: CHAR_W]};
        assign ln_clr[g] = (phase == PH_CLEAR) && s_q.hit && (line == LINE_W'(g));
    end

    always_comb begin
        s_d = s_q;
        case (phase)
            PH_SELECT: begin
                s_d.snap_rdy = ln_rdy[line];
                s_d.snap     = line_word[line];
                s_d.hit      = 1'b0;
            end
            PH_TEST:  s_d.hit = s_q.snap_rdy && !q_full;
            default:  ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign q_push = (phase == PH_WRITE) && s_q.hit;

    rxs_fifo #(.DEPTH(RX_DEPTH)) u_fifo (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_i       (q_push),
        .push_entry_i (s_q.snap),
        .pop_i        (rd_en),
        .head_o       (head),
        .empty_o      (q_empty),
        .full_o       (q_full)
    );

    assign rx_avail = !q_empty;
    assign rd_data  = rx_avail ? {1'b1, head} : '0;
    assign irq      = rx_avail && rx_ie;

    AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ln_clr)); // R4
    AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|ln_clr) |=> (ln_clr == '0)); // R4
    AST_CLR_AFTER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (|ln_clr) |-> $past(q_push)); // R3
endmodule

// File: tb/rxs_scanner_bench.sv
`timescale 1ns/1ps
module rxs_scanner_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ln_rdy = '0, ln_ovr = '0, ln_frm = '0, ln_par = '0;
    logic [63:0] ln_data = '0;
    logic [7:0]  ln_clr;
    logic        rd_en = 1'b0, rx_ie = 1'b0;
    logic [14:0] rd_data;
    logic        rx_avail, irq;

    int n_chk = 0, n_fail = 0, seqno = 0;
    bit done = 1'b0;
    int refill [8];
    logic [7:0] clr_seen = '0;

    // behavioural reference
    int m_ph = 0, m_ln = 0;
    logic m_srdy = 1'b0, m_hit = 1'b0;
    logic [13:0] m_sword = '0;
    logic [13:0] q[$];

    always #2.5 clk = ~clk;

    rxs_scanner u_rxs_scanner (
        .clk(clk), .rst_n(rst_n), .ln_rdy(ln_rdy), .ln_data(ln_data),
        .ln_ovr(ln_ovr), .ln_frm(ln_frm), .ln_par(ln_par), .ln_clr(ln_clr),
        .rd_en(rd_en), .rx_ie(rx_ie), .rd_data(rd_data),
        .rx_avail(rx_avail), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_ln = 0; m_srdy = 1'b0; m_hit = 1'b0; q.delete();
        end else begin
            if (m_ph == 1) m_hit = m_srdy && (q.size() < 64);
            if (rd_en && q.size() > 0) void'(q.pop_front());
            if (m_ph == 0) begin
                m_srdy  = ln_rdy[m_ln];
                m_sword = {3'(m_ln), ln_ovr[m_ln], ln_frm[m_ln], ln_par[m_ln], ln_data[m_ln*8 +: 8]};
                m_hit   = 1'b0;
            end
            if (m_ph == 2 && m_hit) q.push_back(m_sword);
            if (m_ph == 3) m_ln = (m_ln + 1) % 8;
            m_ph = (m_ph + 1) % 4;
        end
    end

    always @(negedge clk) begin
        clr_seen = clr_seen | ln_clr;
        if (rst_n && !done) begin
            if (q.size() == 0) begin
                chk("R7 empty word", 32'(rd_data), 32'd0);
            end else begin
                chk("R7 valid bit", 32'(rd_data[14]), 32'd1);
                chk("R3/R6/R9 head word", 32'(rd_data[13:0]), 32'(q[0]));
            end
            chk("R8 rx_avail", 32'(rx_avail), 32'(q.size() != 0));
            chk("R8 irq", 32'(irq), 32'((q.size() != 0) && rx_ie));
            chk("R2/R4/R5 ln_clr", 32'(ln_clr),
                32'((m_ph == 3 && m_hit) ? (8'd1 << m_ln) : 8'd0));
        end
    end

    task automatic arm(input int i);
        ln_rdy[i] = 1'b1;
        ln_data[i*8 +: 8] = 8'(seqno * 29 + i * 7 + 3);
        ln_ovr[i] = (seqno % 5) == 0;
        ln_frm[i] = (seqno % 7) == 1;
        ln_par[i] = (seqno % 3) == 2;
        seqno++;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        for (int i = 0; i < 8; i++) begin
            if (clr_seen[i]) begin
                if (refill[i] > 0) begin
                    refill[i]--;
                    arm(i);
                end else begin
                    ln_rdy[i] = 1'b0;
                end
            end
        end
        clr_seen = '0;
    endtask

    task automatic run(input int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) refill[i] = 0;
        rx_ie = 1'b1;
        run(3);
        @(negedge clk);
        chk("R1 rd_data in reset", 32'(rd_data), 32'd0);
        chk("R1 rx_avail in reset", 32'(rx_avail), 32'd0);
        chk("R1 irq in reset", 32'(irq), 32'd0);
        chk("R1 ln_clr in reset", 32'(ln_clr), 32'd0);
        step();
        rst_n = 1'b1;

        // scattered lines, some errors
        arm(0); arm(3); arm(7);
        run(40);
        rd_en = 1'b1;
        run(6);          // drains three words, then reads on empty (R7)
        rd_en = 1'b0;
        run(4);

        // interrupt masked, all lines refilling, then constant reading (R9)
        rx_ie = 1'b0;
        for (int i = 0; i < 8; i++) begin refill[i] = 2; arm(i); end
        run(50);
        rx_ie = 1'b1;
        rd_en = 1'b1;
        for (int i = 0; i < 8; i++) refill[i] = 3;
        run(150);
        run(40);
        rd_en = 1'b0;
        run(4);

        // overfill beyond 64 words (R5)
        for (int i = 0; i < 8; i++) begin refill[i] = 9; arm(i); end
        run(420);
        n_chk++;
        if (ln_rdy == 8'd0) begin
            n_fail++;
            $display("FAIL R5 lines held while full: actual=%h expected=nonzero", ln_rdy);
        end
        chk("R5 queue full count", 32'(q.size()), 32'd64);
        rx_ie = 1'b0;
        run(8);
        rx_ie = 1'b1;
        rd_en = 1'b1;
        run(400);
        rd_en = 1'b0;
        run(4);
        chk("R5 held lines later taken", 32'(ln_rdy), 32'd0);
        chk("R6 queue drained", 32'(rx_avail), 32'd0);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end
endmodule